// File: doc/BRIEF.md
# Single-Buffer Network DMA Engine

This block moves packet bytes between system memory and a byte-wide network link, one buffer at a time, under control of a small register file. To send, the driver writes a transmit buffer address and length, then writes 1 to the transmit start register. The engine fetches the buffer as 32-bit words and streams the bytes out in address order. To receive, the driver writes a receive buffer address and length, then arms the receive side. The next frame that arrives is packed into 32-bit word writes with byte enables.

Each direction has its own address, length and start registers, so a transmit and a receive can run at the same time. Completion sets a done flag and raises that direction's interrupt line. A read of the status register clears both. A received frame longer than its buffer is cut at the buffer end and sets an overflow flag. Frames that arrive while receive is not armed are discarded and counted.

Register offsets are word indices on `reg_addr`: 0 transmit address, 1 transmit length, 2 transmit start, 3 receive address, 4 receive length, 5 receive arm, 6 status, 7 received byte count, 8 dropped frame count. Status bits are: bit 0 transmit busy, bit 1 transmit done, bit 2 receive armed, bit 3 receive done, bit 4 receive overflow.

Top module: `nic_dma`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low, and neither `tx_valid` nor `mem_wr_en` is asserted.
- R2: Writing 1 to offset 2 with address X and length Y streams the bytes at memory addresses X to X+Y-1, lowest address first. `tx_last` is set on the final byte. Data and last are held while `tx_ready` is low.
- R3: At the end of a transmit, `irq_tx` rises, status bit 1 sets, and status bit 0 and the read of offset 2 return 0. A start with length 0 completes in the same way and sends no byte.
- R4: Writing 1 to offset 5 arms receive. Status bit 2 stays 1 until a frame has been received. The frame's bytes are stored from the programmed address onward. Offset 7 then reads the number of bytes stored, status bit 3 sets and `irq_rx` rises.
- R5: Bytes of a frame beyond the programmed receive length are not written. Offset 7 then reads the length, and status bit 4 sets and stays set until the next arm.
- R6: Memory writes enable only the byte lanes that belong to the buffer. With an unaligned start address or a partial last word, the bytes next to the buffer keep their values.
- R7: A read of offset 6 returns the status and then clears bits 1 and 3 and both interrupt lines.
- R8: A write to offset 2 while a transmit is busy, or to offset 5 while receive is armed, has no effect. The running operation keeps the address and length it started with.
- R9: A frame that starts while receive is not armed is not written to memory, raises no interrupt, and adds one to the count at offset 8.
- R10: A transmit and a receive may be in progress at the same time, each completing as it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_tx | output | 1 | Transmit-complete interrupt |
| irq_rx | output | 1 | Receive-complete interrupt |
| mem_rd_en | output | 1 | Memory word read request |
| mem_rd_addr | output | AW-2 | Memory read word address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory word write |
| mem_wr_addr | output | AW-2 | Memory write word address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_be | output | 4 | Byte lane enables, bit n for bits 8n+7..8n |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Link accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the buffer |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of a frame |

## Verification
The bench targets unaligned starts and partial words on both paths. A wrong lane choice would corrupt the neighbouring bytes in the receive buffer, or send bytes in the wrong order. It sends a frame longer than its buffer, which a missing bound would let write past the buffer end. It checks that the count and overflow flag then report the truncation. It also starts operations while the engine is busy, where a missing guard would restart a transfer or move its target. It sends frames while receive is unarmed, which a design that got this wrong would write to memory or fail to count. A zero-length transmit and a transmit running alongside a receive round out the cases.

// File: rtl/nic_dma_pkg.sv
package nic_dma_pkg;

  localparam logic [3:0] RA_TX_ADDR = 4'd0;
  localparam logic [3:0] RA_TX_LEN  = 4'd1;
  localparam logic [3:0] RA_TX_GO   = 4'd2;
  localparam logic [3:0] RA_RX_ADDR = 4'd3;
  localparam logic [3:0] RA_RX_LEN  = 4'd4;
  localparam logic [3:0] RA_RX_ARM  = 4'd5;
  localparam logic [3:0] RA_STATUS  = 4'd6;
  localparam logic [3:0] RA_RX_CNT  = 4'd7;
  localparam logic [3:0] RA_DROPS   = 4'd8;

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_CAP, TX_SEND} tx_state_e;

  function automatic logic [3:0] lane_be(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] place_byte(input logic [7:0] b, input logic [1:0] lane);
    return {24'b0, b} << {lane, 3'b000};
  endfunction

  function automatic logic [4:0] status_bits(input logic tx_busy, input logic tx_done,
                                             input logic rx_armed, input logic rx_done,
                                             input logic rx_ovf);
    return {rx_ovf, rx_done, rx_armed, tx_done, tx_busy};
  endfunction

endpackage

// File: rtl/nic_dma_regs.sv
module nic_dma_regs
  import nic_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_busy,
  input  logic          tx_done_p,
  input  logic          rx_armed,
  input  logic          rx_done_p,
  input  logic          rx_ovf,
  input  logic [LW-1:0] rx_count,
  input  logic          rx_drop_p,
  output logic [AW-1:0] tx_addr,
  output logic [LW-1:0] tx_len,
  output logic          tx_start,
  output logic [AW-1:0] rx_addr,
  output logic [LW-1:0] rx_len,
  output logic          rx_start,
  output logic          irq_tx,
  output logic          irq_rx
);

  logic          tx_done_q, rx_done_q, rd_stat;
  logic [CW-1:0] drops;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign rd_stat  = reg_rd && (reg_addr == RA_STATUS);
  assign tx_start = reg_wr && (reg_addr == RA_TX_GO) && reg_wdata[0] && !tx_busy;
  assign rx_start = reg_wr && (reg_addr == RA_RX_ARM) && reg_wdata[0] && !rx_armed;
  assign irq_tx   = tx_done_q;
  assign irq_rx   = rx_done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_addr   <= '0;
      tx_len    <= '0;
      rx_addr   <= '0;
      rx_len    <= '0;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      drops     <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_TX_ADDR: tx_addr <= reg_wdata[AW-1:0];
          RA_TX_LEN:  tx_len  <= reg_wdata[LW-1:0];
          RA_RX_ADDR: rx_addr <= reg_wdata[AW-1:0];
          RA_RX_LEN:  rx_len  <= reg_wdata[LW-1:0];
          default: ;
        endcase
      end
      if (tx_done_p)    tx_done_q <= 1'b1;
      else if (rd_stat) tx_done_q <= 1'b0;
      if (rx_done_p)    rx_done_q <= 1'b1;
      else if (rd_stat) rx_done_q <= 1'b0;
      if (rx_drop_p)    drops <= drops + CW'(1);
    end
  end

  always_comb begin
    case (reg_addr)
      RA_TX_ADDR: reg_rdata = 32'(tx_addr);
      RA_TX_LEN:  reg_rdata = 32'(tx_len);
      RA_TX_GO:   reg_rdata = 32'(tx_busy);
      RA_RX_ADDR: reg_rdata = 32'(rx_addr);
      RA_RX_LEN:  reg_rdata = 32'(rx_len);
      RA_RX_ARM:  reg_rdata = 32'(rx_armed);
      RA_STATUS:  reg_rdata = 32'(status_bits(tx_busy, tx_done_q, rx_armed, rx_done_q, rx_ovf));
      RA_RX_CNT:  reg_rdata = 32'(rx_count);
      RA_DROPS:   reg_rdata = 32'(drops);
      default:    reg_rdata = '0;
    endcase
  end

  AST_IRQ_TX_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $past(tx_done_p)); // R3
  AST_IRQ_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !tx_done_p |=> !irq_tx); // R7
  AST_IRQ_RX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !rx_done_p |=> !irq_rx); // R7
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop_p |=> drops == $past(drops) + CW'(1)); // R9

endmodule

// File: rtl/nic_dma_tx.sv
module nic_dma_tx
  import nic_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic          busy,
  output logic          done_p,
  output logic          mem_rd_en,
  output logic [AW-3:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last
);

  localparam logic [LW-1:0] ONE = LW'(1);

  tx_state_e     state;
  logic [AW-1:0] cur;
  logic [LW-1:0] left;
  logic [31:0]   word;

  assign busy        = (state != TX_IDLE);
  assign mem_rd_en   = (state == TX_REQ);
  assign mem_rd_addr = cur[AW-1:2];
  assign tx_valid    = (state == TX_SEND);
  assign tx_data     = pick_byte(word, cur[1:0]);
  assign tx_last     = tx_valid && (left == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      cur    <= '0;
      left   <= '0;
      word   <= '0;
      done_p <= 1'b0;
    end else begin
      done_p <= 1'b0;
      case (state)
        TX_IDLE: if (start) begin
          if (len == '0) done_p <= 1'b1;
          else begin
            cur   <= base;
            left  <= len;
            state <= TX_REQ;
          end
        end
        TX_REQ: state <= TX_CAP;
        TX_CAP: begin
          word  <= mem_rd_data;
          state <= TX_SEND;
        end
        TX_SEND: if (tx_ready) begin
          cur  <= cur + AW'(1);
          left <= left - ONE;
          if (left == ONE) begin
            state  <= TX_IDLE;
            done_p <= 1'b1;
          end else if (cur[1:0] == 2'd3) begin
            state <= TX_REQ;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R2
  AST_TX_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid); // R2
  AST_TX_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> state == TX_IDLE); // R8

endmodule

// File: rtl/nic_dma_rx.sv
module nic_dma_rx
  import nic_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_in,
  input  logic [LW-1:0] len_in,
  output logic          armed,
  output logic          done_p,
  output logic          ovf,
  output logic [LW-1:0] count,
  output logic          drop_p,
  output logic          mem_wr_en,
  output logic [AW-3:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic [3:0]    mem_wr_be,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last
);

  localparam logic [LW-1:0] ONE = LW'(1);

  logic [AW-1:0] base, cur;
  logic [LW-1:0] len;
  logic          in_frame, receiving;
  logic [31:0]   acc_data, merged;
  logic [3:0]    acc_be, merged_be;
  logic          frame_start, accept_start, take, fits, flush;

  assign frame_start  = rx_valid && !in_frame;
  assign accept_start = frame_start && armed;
  assign drop_p       = frame_start && !armed;
  assign take         = rx_valid && (receiving || accept_start);
  assign cur          = base + AW'(count);
  assign fits         = count < len;
  assign merged       = acc_data | place_byte(rx_data, cur[1:0]);
  assign merged_be    = acc_be | lane_be(cur[1:0]);
  assign flush        = (cur[1:0] == 2'd3) || rx_last || (count + ONE == len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0; len <= '0; count <= '0;
      armed <= 1'b0; in_frame <= 1'b0; receiving <= 1'b0; ovf <= 1'b0;
      acc_data <= '0; acc_be <= '0; done_p <= 1'b0;
      mem_wr_en <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0; mem_wr_be <= '0;
    end else begin
      done_p    <= 1'b0;
      mem_wr_en <= 1'b0;
      if (rx_valid) in_frame <= !rx_last;
      if (start) begin
        armed    <= 1'b1;
        base     <= base_in;
        len      <= len_in;
        count    <= '0;
        ovf      <= 1'b0;
        acc_data <= '0;
        acc_be   <= '0;
      end
      if (accept_start && !rx_last) receiving <= 1'b1;
      if (take) begin
        if (fits) begin
          count <= count + ONE;
          if (flush) begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= cur[AW-1:2];
            mem_wr_data <= merged;
            mem_wr_be   <= merged_be;
            acc_data    <= '0;
            acc_be      <= '0;
          end else begin
            acc_data <= merged;
            acc_be   <= merged_be;
          end
        end else begin
          ovf <= 1'b1;
        end
        if (rx_last) begin
          receiving <= 1'b0;
          armed     <= 1'b0;
          done_p    <= 1'b1;
        end
      end
    end
  end

  AST_RX_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wr_be != 4'b0000); // R6
  AST_RX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ({mem_wr_addr, 2'b00} >= {base[AW-1:2], 2'b00}) &&
                  ({mem_wr_addr, 2'b00} < base + AW'(len))); // R5
  AST_RX_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> count == len); // R5
  AST_RX_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !armed); // R8

endmodule

// File: rtl/nic_dma.sv
module nic_dma #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          mem_rd_en,
  output logic [AW-3:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-3:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic [3:0]    mem_wr_be,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last
);

  logic [AW-1:0] tx_addr, rx_addr;
  logic [LW-1:0] tx_len, rx_len, rx_count;
  logic          tx_start, tx_busy, tx_done_p;
  logic          rx_start, rx_armed, rx_done_p, rx_ovf, rx_drop_p;

  nic_dma_regs #(.AW(AW), .LW(LW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_busy(tx_busy), .tx_done_p(tx_done_p), .rx_armed(rx_armed),
    .rx_done_p(rx_done_p), .rx_ovf(rx_ovf), .rx_count(rx_count), .rx_drop_p(rx_drop_p),
    .tx_addr(tx_addr), .tx_len(tx_len), .tx_start(tx_start),
    .rx_addr(rx_addr), .rx_len(rx_len), .rx_start(rx_start),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  nic_dma_tx #(.AW(AW), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .base(tx_addr), .len(tx_len),
    .busy(tx_busy), .done_p(tx_done_p), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  nic_dma_rx #(.AW(AW), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .base_in(rx_addr), .len_in(rx_len),
    .armed(rx_armed), .done_p(rx_done_p), .ovf(rx_ovf), .count(rx_count),
    .drop_p(rx_drop_p), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last)
  );

endmodule

// File: tb/nic_dma_tb.sv
module nic_dma_tb;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int MSZ = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_tx, irq_rx, mem_rd_en, mem_wr_en, tx_valid, tx_ready, tx_last;
  logic [AW-3:0] mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data = '0, mem_wr_data;
  logic [3:0] mem_wr_be;
  logic [7:0] tx_data;
  logic rx_valid = 0, rx_last = 0;
  logic [7:0] rx_data = '0;

  nic_dma u_dut (.*);

  always #10 clk = ~clk;

  int cyc = 0, total = 0, bad = 0, tx_seen = 0;
  logic bp_mode = 1'b0;
  logic [7:0] mem [MSZ];
  logic [7:0] exp_mem [MSZ];
  logic [7:0] txq [$];

  always @(posedge clk) cyc <= cyc + 1;
  assign tx_ready = !bp_mode || (cyc[0] ^ cyc[2]);

  always @(posedge clk) begin : memory_model
    int ra, wa;
    ra = (int'(mem_rd_addr) * 4) % MSZ;
    wa = (int'(mem_wr_addr) * 4) % MSZ;
    if (mem_rd_en) mem_rd_data <= {mem[ra+3], mem[ra+2], mem[ra+1], mem[ra]};
    if (mem_wr_en)
      for (int b = 0; b < 4; b++)
        if (mem_wr_be[b]) mem[wa+b] <= mem_wr_data[8*b +: 8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference comparison of each accepted transmit byte against the expected queue (R2)
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      logic [7:0] e;
      tx_seen++;
      total++;
      if (txq.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected byte act=%h exp=none", tx_data);
      end else begin
        e = txq.pop_front();
        if (tx_data !== e || tx_last !== (txq.size() == 0)) begin
          bad++;
          $display("FAIL R2 byte act=%h/%b exp=%h/%b", tx_data, tx_last, e, txq.size() == 0);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_irq(input bit rx, input string tag);
    int n = 0;
    while ((rx ? irq_rx : irq_tx) !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
    chk(tag, rx ? irq_rx : irq_tx, 1'b1);
  endtask

  task automatic tx_run(input int addr, input int len);
    for (int i = 0; i < len; i++) txq.push_back(mem[addr+i]);
    wr(4'd0, addr); wr(4'd1, len); wr(4'd2, 1);
    wait_irq(0, "R3 irq_tx after transmit");
    chk("R2 all bytes sent", txq.size(), 0);
  endtask

  task automatic send_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'(seed + 7*i); rx_last = (i == n-1);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic expect_rx(input int addr, input int len, input int n, input int seed);
    for (int i = 0; i < n && i < len; i++) exp_mem[addr+i] = 8'(seed + 7*i);
  endtask

  task automatic mem_cmp(input string tag);
    int errs = 0, first = -1;
    for (int i = 0; i < MSZ; i++)
      if (mem[i] !== exp_mem[i]) begin errs++; if (first < 0) first = i; end
    total++;
    if (errs != 0) begin
      bad++;
      $display("FAIL %s mismatches=%0d at %0d act=%h exp=%h", tag, errs, first,
               mem[first], exp_mem[first]);
    end
  endtask

  task automatic arm(input int addr, input int len);
    wr(4'd3, addr); wr(4'd4, len); wr(4'd5, 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MSZ; i++) begin mem[i] = 8'(i*13 + 5); exp_mem[i] = 8'(i*13 + 5); end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_tx", irq_tx, 0); chk("R1 irq_rx", irq_rx, 0);
    chk("R1 tx_valid", tx_valid, 0); chk("R1 mem_wr_en", mem_wr_en, 0);
    rd_chk("R1 status", 4'd6, 0); rd_chk("R1 drops", 4'd8, 0); rd_chk("R1 tx len", 4'd1, 0);

    // R2 R3 aligned transmit, no backpressure; R7 status read clears
    tx_run(32'h40, 8);
    rd_chk("R3 go self-clears", 4'd2, 0);
    rd_chk("R3 status done", 4'd6, 32'h2);
    chk("R7 irq_tx cleared", irq_tx, 0);
    rd_chk("R7 done bit cleared", 4'd6, 0);

    // R2 unaligned start with backpressure
    bp_mode = 1;
    tx_run(32'h43, 7);
    rd_chk("R3 status after unaligned", 4'd6, 32'h2);

    // R3 zero length
    tx_seen = 0;
    tx_run(32'h50, 0);
    repeat (10) @(negedge clk);
    chk("R3 zero length sends nothing", tx_seen, 0);
    rd_chk("R3 zero length status", 4'd6, 32'h2);

    // R8 start while busy ignored
    tx_seen = 0;
    for (int i = 0; i < 20; i++) txq.push_back(mem[32'h70 + i]);
    wr(4'd0, 32'h70); wr(4'd1, 20); wr(4'd2, 1);
    wr(4'd0, 32'h90); wr(4'd2, 1);
    wait_irq(0, "R8 irq_tx");
    repeat (40) @(negedge clk);
    chk("R8 byte count after busy go", tx_seen, 20);
    chk("R8 tx idle", tx_valid, 0);
    rd_chk("R8 status", 4'd6, 32'h2);
    bp_mode = 0;

    // R4 receive into aligned buffer
    arm(32'h100, 16);
    repeat (30) @(negedge clk);
    rd_chk("R4 stays armed", 4'd6, 32'h4);
    send_frame(10, 3);
    expect_rx(32'h100, 16, 10, 3);
    wait_irq(1, "R4 irq_rx");
    mem_cmp("R4 memory");
    rd_chk("R4 count", 4'd7, 10);
    rd_chk("R4 status", 4'd6, 32'h8);

    // R6 unaligned start and partial tail
    arm(32'h203, 6);
    send_frame(6, 40);
    expect_rx(32'h203, 6, 6, 40);
    wait_irq(1, "R6 irq_rx");
    mem_cmp("R6 neighbours kept");
    rd_chk("R6 count", 4'd7, 6);
    rd_chk("R6 status", 4'd6, 32'h8);

    // R5 truncation
    arm(32'h300, 5);
    send_frame(9, 90);
    expect_rx(32'h300, 5, 9, 90);
    wait_irq(1, "R5 irq_rx");
    mem_cmp("R5 no write past end");
    rd_chk("R5 count", 4'd7, 5);
    rd_chk("R5 status ovf", 4'd6, 32'h18);

    // R9 unarmed frames dropped
    send_frame(4, 120);
    repeat (5) @(negedge clk);
    rd_chk("R9 drops one", 4'd8, 1);
    chk("R9 no irq_rx", irq_rx, 0);
    mem_cmp("R9 memory untouched");
    send_frame(3, 150);
    repeat (5) @(negedge clk);
    rd_chk("R9 drops two", 4'd8, 2);

    // R8 arm while armed ignored
    arm(32'h180, 8);
    wr(4'd3, 32'h1C0); wr(4'd4, 2); wr(4'd5, 1);
    send_frame(8, 200);
    expect_rx(32'h180, 8, 8, 200);
    wait_irq(1, "R8 irq_rx");
    mem_cmp("R8 original buffer kept");
    rd_chk("R8 count", 4'd7, 8);
    rd_chk("R8 rx status", 4'd6, 32'h8);

    // R10 both directions at once
    arm(32'h280, 12);
    fork
      tx_run(32'h60, 10);
      begin repeat (3) @(negedge clk); send_frame(12, 11); end
    join
    expect_rx(32'h280, 12, 12, 11);
    wait_irq(1, "R10 irq_rx");
    chk("R10 irq_tx", irq_tx, 1);
    mem_cmp("R10 memory");
    rd_chk("R10 status", 4'd6, 32'hA);
    rd_chk("R10 status cleared", 4'd6, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule